// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This controller runs a complete test session on a circuit in which only some flip-flops are scanned. The scanned flip-flops sit on one clock enable and the rest sit on a second one. In shift cycles only the scan clock runs and the non-scan flip-flops hold their state. In capture cycles both clocks run together.

A session has three parts. It first checks the scan register itself by shifting a repeating two-zeros, two-ones pattern for chain length plus four cycles. Each test vector then gets a serial load of chain-length shifts followed by one capture cycle. A single unload of chain-length shifts closes the session. The unload of each response overlaps the load of the next vector, so the session takes exactly (vectors+2)·chain + vectors + 4 cycles.

Vector bits live outside the block. The block names the bit it wants through a vector index and a bit index, and reads it back on a single input bit in the same cycle. A cycle counter and a done flag let the surrounding logic confirm the session length.

Top module: `partial_scan_seq`

## Requirements
- R1: While reset is low, and afterwards until start, test_ctl, scan_clk_en, nscan_clk_en, pi_load and done are 0 and cyc_cnt is 0.
- R2: In every capture cycle nscan_clk_en and scan_clk_en are both 1 and test_ctl is 0.
- R3: In every shift cycle test_ctl and scan_clk_en are 1 and nscan_clk_en is 0.
- R4: The first session cycle is the cycle after start is sampled high. The session opens with N_SFF+4 shift cycles. In flush cycle k (counted from 0), scan_in = (k>>1)&1, giving 0,0,1,1,...
- R5: Vector v (0..N_VEC-1) takes N_SFF shift cycles. During these, vec_idx = v and bit_idx runs 0..N_SFF-1 in order, and scan_in equals vec_bit. One capture cycle follows.
- R6: pi_load is 1 only in the last shift cycle of each vector load, which is one cycle before that vector's capture. vec_idx names the vector in that cycle.
- R7: After the last capture, N_SFF unload shift cycles follow with scan_in = 0. done goes to 1 in the next cycle and stays there until a new start.
- R8: cyc_cnt equals the number of session cycles already elapsed, 0 in the first. When done rises, cyc_cnt equals (N_VEC+2)·N_SFF + N_VEC + 4, and exactly that many cycles had scan_clk_en high.
- R9: start has no effect while a session is running.
- R10: start sampled while done is 1 begins a new identical session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a session from idle or done |
| vec_bit | input | 1 | Stored vector bit at vec_idx/bit_idx |
| test_ctl | output | 1 | Scan-enable: 1 in shift cycles |
| scan_clk_en | output | 1 | Clock enable of scanned flip-flops |
| nscan_clk_en | output | 1 | Clock enable of non-scanned flip-flops |
| scan_in | output | 1 | Serial bit into the chain |
| pi_load | output | 1 | Primary-input load strobe |
| vec_idx | output | max(1,clog2(N_VEC)) | Current vector index |
| bit_idx | output | max(1,clog2(N_SFF)) | Current bit index within the vector |
| cyc_cnt | output | clog2(TOTAL+1) | Elapsed session cycles |
| done | output | 1 | Session finished |

## Verification
The bench builds the block with a chain of 5 and 3 vectors, which gives a 32-cycle session. At that size it can compare every cycle against a position-based model: the flush pattern through more than one full period, every load bit of every vector, each strobe and capture, and the unload. The vector store is an arithmetic function of the indices, so a wrong bit order or a wrong vector shows up directly. It also covers a start pulse in mid-session, a reset in mid-session, and a restart from done.

// File: rtl/ps_seq_pkg.sv
// Shared types for the partial-scan sequencer.
// Assumes: nothing; holds only the phase encoding.
package ps_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FLUSH  = 3'd1,
        PH_LOAD   = 3'd2,
        PH_CAPT   = 3'd3,
        PH_UNLOAD = 3'd4,
        PH_DONE   = 3'd5
    } phase_t;
endpackage

// File: rtl/ps_seq_fsm.sv
// Phase sequencer: walks flush, per-vector load/capture and the final unload.
// Assumes N_SFF >= 1 and N_VEC >= 1. The bit counter is wide enough for the flush length.
module ps_seq_fsm
    import ps_seq_pkg::*;
#(
    parameter int N_SFF = 5,
    parameter int N_VEC = 3,
    parameter int BW    = 4,
    parameter int VW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output phase_t        phase,
    output logic [BW-1:0] bcnt,
    output logic [VW-1:0] vcnt,
    output logic          start_acc
);
    localparam logic [BW-1:0] FLUSH_LAST = BW'(N_SFF + 3);
    localparam logic [BW-1:0] SHIFT_LAST = BW'(N_SFF - 1);
    localparam logic [VW-1:0] VEC_LAST   = VW'(N_VEC - 1);

    // start is taken only when no session is running
    assign start_acc = start && (phase == PH_IDLE || phase == PH_DONE);

    // advance phase and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            bcnt  <= '0;
            vcnt  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE, PH_DONE: begin
                    if (start_acc) begin
                        phase <= PH_FLUSH;
                        bcnt  <= '0;
                        vcnt  <= '0;
                    end
                end
                PH_FLUSH: begin
                    if (bcnt == FLUSH_LAST) begin
                        phase <= PH_LOAD;
                        bcnt  <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                PH_LOAD: begin
                    if (bcnt == SHIFT_LAST) begin
                        phase <= PH_CAPT;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                PH_CAPT: begin
                    bcnt <= '0;
                    if (vcnt == VEC_LAST) begin
                        phase <= PH_UNLOAD;
                    end else begin
                        phase <= PH_LOAD;
                        vcnt  <= vcnt + 1'b1;
                    end
                end
                PH_UNLOAD: begin
                    if (bcnt == SHIFT_LAST) begin
                        phase <= PH_DONE;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ps_flush_pattern.sv
// Scan-register test pattern: yields 0,0,1,1 repeating over the flush index.
// Assumes the index starts at 0 on the first flush cycle.
module ps_flush_pattern #(
    parameter int BW = 4
) (
    input  logic [BW-1:0] idx,
    output logic          bit_o
);
    // the pattern bit is the index's weight-two bit
    generate
        if (BW >= 2) begin : g_wide
            assign bit_o = idx[1];
        end else begin : g_narrow
            assign bit_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ps_cycle_counter.sv
// Session cycle counter: cleared on session start, counts active cycles.
// Assumes the width holds the full session length.
module ps_cycle_counter #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    // clear on start, increment in each session cycle
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/partial_scan_seq.sv
// Partial-scan test sequencer top. Produces the scan-enable, both clock
// enables, the serial chain input and the primary-input strobe for a whole session.
// Assumes an external vector store that answers vec_idx/bit_idx in the same cycle.
module partial_scan_seq
    import ps_seq_pkg::*;
#(
    parameter int N_SFF = 5,
    parameter int N_VEC = 3,
    localparam int TOTAL = (N_VEC + 2) * N_SFF + N_VEC + 4,
    localparam int BW    = $clog2(N_SFF + 5),
    localparam int VW    = (N_VEC > 1) ? $clog2(N_VEC) : 1,
    localparam int BIW   = (N_SFF > 1) ? $clog2(N_SFF) : 1,
    localparam int CW    = $clog2(TOTAL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           vec_bit,
    output logic           test_ctl,
    output logic           scan_clk_en,
    output logic           nscan_clk_en,
    output logic           scan_in,
    output logic           pi_load,
    output logic [VW-1:0]  vec_idx,
    output logic [BIW-1:0] bit_idx,
    output logic [CW-1:0]  cyc_cnt,
    output logic           done
);
    phase_t        phase;
    logic [BW-1:0] bcnt;
    logic [VW-1:0] vcnt;
    logic          start_acc;
    logic          flush_bit;
    logic          shifting;
    logic          capturing;

    ps_seq_fsm #(.N_SFF(N_SFF), .N_VEC(N_VEC), .BW(BW), .VW(VW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .phase(phase), .bcnt(bcnt), .vcnt(vcnt), .start_acc(start_acc)
    );

    ps_flush_pattern #(.BW(BW)) u_flush (.idx(bcnt), .bit_o(flush_bit));

    ps_cycle_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc),
        .inc(shifting || capturing), .cnt(cyc_cnt)
    );

    // decode the phase into shift and capture cycles
    assign shifting  = (phase == PH_FLUSH) || (phase == PH_LOAD) || (phase == PH_UNLOAD);
    assign capturing = (phase == PH_CAPT);

    // clock enables and scan-enable
    assign test_ctl     = shifting;
    assign scan_clk_en  = shifting || capturing;
    assign nscan_clk_en = capturing;

    // serial input: flush pattern, vector bit, or zero during unload
    always_comb begin
        unique case (phase)
            PH_FLUSH: scan_in = flush_bit;
            PH_LOAD:  scan_in = vec_bit;
            default:  scan_in = 1'b0;
        endcase
    end

    // vector store addressing and primary-input strobe
    assign vec_idx = vcnt;
    assign bit_idx = bcnt[BIW-1:0];
    assign pi_load = (phase == PH_LOAD) && (bcnt == BW'(N_SFF - 1));
    assign done    = (phase == PH_DONE);
endmodule

// File: rtl/ps_seq_checker.sv
// Temporal checks on the partial-scan sequencer ports, bound to the top.
module ps_seq_checker #(
    parameter int N_SFF = 5,
    parameter int N_VEC = 3,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          test_ctl,
    input logic          scan_clk_en,
    input logic          nscan_clk_en,
    input logic          pi_load,
    input logic          done,
    input logic [CW-1:0] cyc_cnt
);
    localparam int TOTAL = (N_VEC + 2) * N_SFF + N_VEC + 4;

    a_r2_capture_both: assert property (@(posedge clk) disable iff (!rst_n)
        nscan_clk_en |-> (scan_clk_en && !test_ctl));
    a_r3_shift_scan_only: assert property (@(posedge clk) disable iff (!rst_n)
        test_ctl |-> (scan_clk_en && !nscan_clk_en));
    a_r2_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        nscan_clk_en |=> !nscan_clk_en);
    a_r6_load_then_capture: assert property (@(posedge clk) disable iff (!rst_n)
        pi_load |=> nscan_clk_en);
    a_r7_done_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(test_ctl));
    a_r8_done_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_cnt == CW'(TOTAL)));
    a_r1_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_clk_en && !pi_load));
endmodule

bind partial_scan_seq ps_seq_checker #(.N_SFF(N_SFF), .N_VEC(N_VEC), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .test_ctl(test_ctl), .scan_clk_en(scan_clk_en),
    .nscan_clk_en(nscan_clk_en), .pi_load(pi_load), .done(done), .cyc_cnt(cyc_cnt)
);

// File: tb/partial_scan_seq_tb.sv
// Cycle-exact bench: every session cycle is compared with a position-based model.
module partial_scan_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;
    localparam int NV = 3;
    localparam int FL = NS + 4;
    localparam int TOT = (NV + 2) * NS + NV + 4;

    logic clk = 0, rst_n = 0, start = 0, vec_bit;
    logic test_ctl, scan_clk_en, nscan_clk_en, scan_in, pi_load, done;
    logic [1:0] vec_idx;
    logic [2:0] bit_idx;
    logic [5:0] cyc_cnt;
    int checks = 0, errors = 0, scan_cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    partial_scan_seq #(.N_SFF(NS), .N_VEC(NV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_bit(vec_bit),
        .test_ctl(test_ctl), .scan_clk_en(scan_clk_en), .nscan_clk_en(nscan_clk_en),
        .scan_in(scan_in), .pi_load(pi_load), .vec_idx(vec_idx), .bit_idx(bit_idx),
        .cyc_cnt(cyc_cnt), .done(done)
    );

    function automatic logic mem(input int v, input int b);
        return logic'(((v * 3 + b * 5 + 1) % 7) > 3);
    endfunction

    assign vec_bit = mem(int'(vec_idx), int'(bit_idx));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk({test_ctl, scan_clk_en, nscan_clk_en, pi_load, done} == 5'b0 && cyc_cnt == 0,
            req, {test_ctl, scan_clk_en, nscan_clk_en, pi_load, done}, 0);
    endtask

    // compare one session cycle k against the model
    task automatic chk_cycle(input int k);
        int j, v, p;
        if (scan_clk_en) scan_cycles++;
        chk(cyc_cnt == 6'(k), "R8 cyc_cnt", cyc_cnt, k);
        if (k < FL) begin
            chk(test_ctl && scan_clk_en && !nscan_clk_en, "R3 flush enables",
                {test_ctl, scan_clk_en, nscan_clk_en}, 3'b110);
            chk(scan_in == logic'((k >> 1) & 1), "R4 flush pattern", scan_in, (k >> 1) & 1);
            chk(!pi_load, "R6 no strobe in flush", pi_load, 0);
        end else begin
            j = k - FL;
            if (j < NV * (NS + 1)) begin
                v = j / (NS + 1);
                p = j % (NS + 1);
                chk(vec_idx == 2'(v), "R5 vec_idx", vec_idx, v);
                if (p < NS) begin
                    chk(test_ctl && scan_clk_en && !nscan_clk_en, "R3 load enables",
                        {test_ctl, scan_clk_en, nscan_clk_en}, 3'b110);
                    chk(bit_idx == 3'(p), "R5 bit_idx", bit_idx, p);
                    chk(scan_in == mem(v, p), "R5 scan_in", scan_in, mem(v, p));
                    chk(pi_load == (p == NS - 1), "R6 pi_load", pi_load, p == NS - 1);
                end else begin
                    chk(!test_ctl && scan_clk_en && nscan_clk_en, "R2 capture enables",
                        {test_ctl, scan_clk_en, nscan_clk_en}, 3'b011);
                    chk(!pi_load, "R6 no strobe in capture", pi_load, 0);
                end
            end else begin
                chk(test_ctl && scan_clk_en && !nscan_clk_en, "R7 unload enables",
                    {test_ctl, scan_clk_en, nscan_clk_en}, 3'b110);
                chk(scan_in == 1'b0 && !pi_load, "R7 unload data", scan_in, 0);
            end
        end
        chk(!done, "R7 done low in session", done, 0);
    endtask

    // run one full session; pulse start at cycle poke (R9) if poke >= 0
    task automatic run_session(input int poke);
        scan_cycles = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        for (int k = 0; k < TOT; k++) begin
            start = (k == poke);
            chk_cycle(k);
            @(negedge clk);
        end
        start = 0;
        chk(done == 1'b1, "R7 done after unload", done, 1);
        chk(cyc_cnt == 6'(TOT), "R8 total length", cyc_cnt, TOT);
        chk(scan_cycles == TOT, "R8 scan clock count", scan_cycles, TOT);
        repeat (3) @(negedge clk);
        chk(done && !scan_clk_en, "R7 done holds", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk_idle("R1 idle after reset");
        run_session(-1);
        run_session(10);   // R9: start in mid-session ignored; also R10 restart from done
        // mid-session reset returns to idle (R1)
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        repeat (7) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk_idle("R1 reset mid-session");
        rst_n = 1;
        @(negedge clk);
        chk_idle("R1 idle after mid reset");
        run_session(-1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule